// File: doc/BRIEF.md
# Sleep Quarterbit Counter Handover

This block keeps the position inside a radio frame while the fast reference clock is stopped for low-power sleep. While awake, a quarterbit counter advances by one on each quarterbit strobe. It runs through 5000 positions per frame and raises a one-cycle frame pulse each time it returns to zero. When sleep is requested, the current position is copied into a sleep counter. That counter then advances by a programmable step, close to the quarterbit-to-sleep-clock ratio, on each slow sleep-clock strobe. When the request is withdrawn, the sleep counter's position is copied back and fine counting carries on from it.

The block runs on one clock and receives two enable strobes: one at the quarterbit rate and one at the slow sleep rate. While asleep it stops frame pulses and burst timing, and it clears and locks two mode registers.

Top module: `sqbc_handover`

## Requirements
- R1: After a synchronous active-low reset, both counters read 0, `asleep` is 0, `frame_irq` is 0 and both mode registers are 0.
- R2: While awake, each cycle with `qb_en` high moves `qb_count` up by one, with 4999 followed by 0. Without `qb_en`, `qb_count` keeps its value.
- R3: `frame_irq` is high for exactly the one cycle in which `qb_count` has just wrapped from 4999 to 0 while awake.
- R4: The first cycle with `sleep_req` high while awake is the entry cycle. After that edge `sleep_count` equals the value `qb_count` had, `asleep` is 1, and `qb_count` has not advanced even if `qb_en` was high.
- R5: While asleep, each cycle with `slp_en` high sets `sleep_count` to (`sleep_count` + `slp_inc`) mod 5000. Without `slp_en`, `sleep_count` holds. `qb_en` has no effect on `qb_count`.
- R6: The first cycle with `sleep_req` low while asleep is the exit cycle. After that edge `qb_count` equals the value `sleep_count` had, `asleep` is 0, and a `slp_en` in that cycle is not applied. Later `qb_en` strobes count on from the copied value.
- R7: `frame_irq` stays 0 for the whole time `asleep` is 1.
- R8: A write with `mode_we` high loads `mode_wdata` into `mode0` when `mode_sel` is 0 and into `mode1` when `mode_sel` is 1. The entry cycle clears both registers. Writes are ignored while asleep.
- R9: `sleep_count` never leaves the range 0 to 4999, including when the step is 255 and the sum crosses 5000 many times.
- R10: Keeping `sleep_req` high copies the position only once. `sleep_count` is not reloaded from `qb_count` after the entry cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qb_en | input | 1 | Quarterbit-rate strobe |
| slp_en | input | 1 | Sleep-rate strobe |
| sleep_req | input | 1 | High requests sleep, low requests normal timing |
| slp_inc | input | 8 | Step added per sleep strobe |
| mode_we | input | 1 | Mode register write strobe |
| mode_sel | input | 1 | Mode register select (0 or 1) |
| mode_wdata | input | 8 | Mode register write data |
| qb_count | output | 13 | Quarterbit position, 0 to 4999 |
| sleep_count | output | 13 | Sleep counter position, 0 to 4999 |
| asleep | output | 1 | High while in sleep |
| frame_irq | output | 1 | One-cycle pulse on frame wrap |
| mode0 | output | 8 | Mode register 0 |
| mode1 | output | 8 | Mode register 1 |

## Verification
The handover is exercised with a mid-frame start and a step of 123 over 40 sleep strobes. In that run, idle cycles and `qb_en` strobes are mixed in, so the test separates a copy made once from repeated reloads and exposes any leakage of fast strobes into the sleep counter. A step of 255 over 100 strobes crosses the 5000 boundary repeatedly, which exposes a missing or double modulo correction. A step of 0 shows that the counter holds rather than drifts. The exit cycle carries a sleep strobe, which shows whether the copied-back value is the pre-strobe one. Counting after the exit then shows that fine timing resumes from it.

// File: rtl/sqbc_pkg.sv
// Shared sizing for the quarterbit handover block.
// Assumes a frame of 5000 quarterbit positions and an 8-bit sleep step.
package sqbc_pkg;
    localparam int FRAME_LEN = 5000;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int INC_W     = 8;
    localparam int MODE_W    = 8;
    localparam int MODE_N    = 2;
endpackage

// File: rtl/sqbc_sleep_fsm.sv
// Tracks the sleep/awake state and produces single-cycle entry and exit
// strobes from the level of the sleep request.
// Assumes sleep_req is already synchronous to clk.
module sqbc_sleep_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic asleep,
    output logic enter,
    output logic leave
);
    logic asleep_q;

    // Entry and exit are the cycles where request and state disagree.
    assign enter  = sleep_req && !asleep_q;
    assign leave  = !sleep_req && asleep_q;
    assign asleep = asleep_q;

    // State register follows the request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) asleep_q <= 1'b0;
        else        asleep_q <= sleep_req;
    end

    assert_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> asleep);
    assert_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> !asleep);
endmodule

// File: rtl/sqbc_qb_counter.sv
// Fine quarterbit counter: steps by one per strobe while running, wraps at
// the end of the frame with a one-cycle pulse, and can be loaded.
// Assumes load and run are never both high.
module sqbc_qb_counter #(
    parameter int FRAME_LEN = sqbc_pkg::FRAME_LEN,
    parameter int CNT_W     = sqbc_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_irq
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    // Counter and frame pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            wrap_irq <= 1'b0;
        end else begin
            wrap_irq <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (run && step) begin
                if (cnt == LAST) begin
                    cnt      <= '0;
                    wrap_irq <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_qb_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    assert_qb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && step)) |=> $stable(cnt));
    assert_irq_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq |-> (cnt == '0));
endmodule

// File: rtl/sqbc_sleep_counter.sv
// Coarse sleep counter: adds a programmable step per slow strobe modulo
// the frame length, and is loaded from the fine counter on sleep entry.
// Assumes the step is smaller than the frame length.
module sqbc_sleep_counter #(
    parameter int FRAME_LEN = sqbc_pkg::FRAME_LEN,
    parameter int CNT_W     = sqbc_pkg::CNT_W,
    parameter int INC_W     = sqbc_pkg::INC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [INC_W-1:0] inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] LEN_X = (CNT_W+1)'(FRAME_LEN);

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] next_pos;

    // Modular add: one subtraction suffices since the step is below the frame length.
    always_comb begin
        sum      = {1'b0, cnt} + (CNT_W+1)'(inc);
        next_pos = (sum >= LEN_X) ? CNT_W'(sum - LEN_X) : CNT_W'(sum);
    end

    // Load on entry, otherwise step on each slow strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (run && tick)  cnt <= next_pos;
    end

    assert_sq_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(FRAME_LEN));
    assert_sq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(cnt));
endmodule

// File: rtl/sqbc_mode_regs.sv
// Bank of mode registers written by select; cleared on sleep entry and
// locked against writes while asleep.
// Assumes clear is only raised in the entry cycle.
module sqbc_mode_regs #(
    parameter int MODE_W = sqbc_pkg::MODE_W,
    parameter int MODE_N = sqbc_pkg::MODE_N,
    parameter int SEL_W  = (MODE_N > 1) ? $clog2(MODE_N) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock,
    input  logic                    clear,
    input  logic                    we,
    input  logic [SEL_W-1:0]        sel,
    input  logic [MODE_W-1:0]       wdata,
    output logic [MODE_N*MODE_W-1:0] regs
);
    for (genvar i = 0; i < MODE_N; i++) begin : g_reg
        logic [MODE_W-1:0] r;
        // One register: clear on entry, write when unlocked and selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  r <= '0;
            else if (clear)                              r <= '0;
            else if (we && !lock && sel == SEL_W'(i))    r <= wdata;
        end
        assign regs[i*MODE_W +: MODE_W] = r;

        assert_mode_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lock && !clear) |=> $stable(r));
    end
endmodule

// File: rtl/sqbc_handover.sv
// Top: hands the frame position between the fine quarterbit counter and the
// coarse sleep counter, gates the frame pulse and clears mode registers.
// Assumes a single clock with qb_en and slp_en strobes already synchronous.
module sqbc_handover (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       qb_en,
    input  logic       slp_en,
    input  logic       sleep_req,
    input  logic [7:0] slp_inc,
    input  logic       mode_we,
    input  logic       mode_sel,
    input  logic [7:0] mode_wdata,
    output logic [12:0] qb_count,
    output logic [12:0] sleep_count,
    output logic       asleep,
    output logic       frame_irq,
    output logic [7:0] mode0,
    output logic [7:0] mode1
);
    import sqbc_pkg::*;

    logic enter, leave, asleep_i;
    logic qb_run, sq_run;
    logic [CNT_W-1:0] qb_i, sq_i;
    logic [MODE_N*MODE_W-1:0] mode_bus;

    // Fine counter runs only while awake and not entering; coarse only while asleep and not leaving.
    assign qb_run = !asleep_i && !enter;
    assign sq_run = asleep_i && !leave;

    sqbc_sleep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .asleep(asleep_i), .enter(enter), .leave(leave)
    );

    sqbc_qb_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_qb (
        .clk(clk), .rst_n(rst_n), .run(qb_run), .step(qb_en),
        .load(leave), .load_val(sq_i), .cnt(qb_i), .wrap_irq(frame_irq)
    );

    sqbc_sleep_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .INC_W(INC_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .run(sq_run), .tick(slp_en), .inc(slp_inc),
        .load(enter), .load_val(qb_i), .cnt(sq_i)
    );

    sqbc_mode_regs #(.MODE_W(MODE_W), .MODE_N(MODE_N)) u_mode (
        .clk(clk), .rst_n(rst_n), .lock(asleep_i || enter), .clear(enter),
        .we(mode_we), .sel(mode_sel), .wdata(mode_wdata), .regs(mode_bus)
    );

    assign qb_count    = qb_i;
    assign sleep_count = sq_i;
    assign asleep      = asleep_i;
    assign mode0       = mode_bus[0 +: MODE_W];
    assign mode1       = mode_bus[MODE_W +: MODE_W];

    assert_copy_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (sleep_count == $past(qb_count)) && (qb_count == $past(qb_count)));
    assert_copy_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        leave |=> (qb_count == $past(sleep_count)));
    assert_no_irq_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !frame_irq);
    assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> (mode0 == '0) && (mode1 == '0));
    assert_qb_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !leave) |=> $stable(qb_count));
    assert_single_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !leave && !slp_en) |=> $stable(sleep_count));
endmodule

// File: tb/sqbc_handover_test.sv
module sqbc_handover_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic qb_en = 0, slp_en = 0, sleep_req = 0, mode_we = 0, mode_sel = 0;
    logic [7:0] slp_inc = '0, mode_wdata = '0;
    logic [12:0] qb_count, sleep_count;
    logic asleep, frame_irq;
    logic [7:0] mode0, mode1;

    int checks = 0;
    int errors = 0;
    int exp_qb = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sqbc_handover uut (
        .clk(clk), .rst_n(rst_n), .qb_en(qb_en), .slp_en(slp_en),
        .sleep_req(sleep_req), .slp_inc(slp_inc), .mode_we(mode_we),
        .mode_sel(mode_sel), .mode_wdata(mode_wdata), .qb_count(qb_count),
        .sleep_count(sleep_count), .asleep(asleep), .frame_irq(frame_irq),
        .mode0(mode0), .mode1(mode1)
    );

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cycles);
            report();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    task automatic run_qb(int n);
        qb_en = 1;
        for (int i = 0; i < n; i++) step();
        qb_en = 0;
        exp_qb = (exp_qb + n) % 5000;
    endtask

    task automatic t_reset();
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1", "qb_count", qb_count, 0);
        chk("R1", "sleep_count", sleep_count, 0);
        chk("R1", "asleep", asleep, 0);
        chk("R1", "frame_irq", frame_irq, 0);
        chk("R1", "mode0|mode1", {mode0, mode1}, 0);
    endtask

    task automatic t_count();
        run_qb(10);
        chk("R2", "count after 10", qb_count, exp_qb);
        repeat (5) step();
        chk("R2", "hold without qb_en", qb_count, exp_qb);
    endtask

    task automatic t_wrap();
        int irqs = 0;
        run_qb(4999 - exp_qb);
        chk("R2", "reach 4999", qb_count, 4999);
        chk("R3", "no irq before wrap", irqs + frame_irq, 0);
        qb_en = 1;
        step();
        qb_en = 0;
        exp_qb = 0;
        chk("R2", "wrap to 0", qb_count, 0);
        chk("R3", "irq on wrap", frame_irq, 1);
        step();
        chk("R3", "irq one cycle", frame_irq, 0);
    endtask

    task automatic t_sleep_handover();
        int start, exp_sq, n_ticks, irqs;
        run_qb(1234);
        mode_we = 1; mode_sel = 0; mode_wdata = 8'hA5; step();
        mode_sel = 1; mode_wdata = 8'h3C; step();
        mode_we = 0;
        chk("R8", "mode0 write", mode0, 8'hA5);
        chk("R8", "mode1 write", mode1, 8'h3C);
        start = exp_qb;
        sleep_req = 1; qb_en = 1;
        step();
        qb_en = 0;
        chk("R4", "sleep_count copy", sleep_count, start);
        chk("R4", "asleep set", asleep, 1);
        chk("R4", "qb held in entry", qb_count, start);
        chk("R8", "modes cleared", {mode0, mode1}, 0);
        slp_inc = 8'd123;
        n_ticks = 0; irqs = 0;
        for (int i = 0; i < 40; i++) begin
            slp_en = 1; qb_en = (i % 3 == 0); mode_we = (i == 5); mode_wdata = 8'h77;
            step();
            n_ticks++;
            irqs += frame_irq;
            slp_en = 0; qb_en = 1; mode_we = 0;
            step();
            irqs += frame_irq;
            qb_en = 0;
            if (i == 19) chk("R5", "mid sleep value", sleep_count, (start + n_ticks * 123) % 5000);
        end
        exp_sq = (start + 40 * 123) % 5000;
        chk("R5", "after 40 ticks", sleep_count, exp_sq);
        chk("R10", "no reload from qb", sleep_count, exp_sq);
        chk("R5", "qb frozen", qb_count, start);
        chk("R7", "irq count asleep", irqs, 0);
        chk("R8", "write ignored asleep", {mode0, mode1}, 0);
        sleep_req = 0; slp_en = 1;
        step();
        slp_en = 0;
        exp_qb = exp_sq;
        chk("R6", "qb copy back", qb_count, exp_sq);
        chk("R6", "exit tick ignored", sleep_count, exp_sq);
        chk("R6", "asleep clear", asleep, 0);
        run_qb(5);
        chk("R6", "resume counting", qb_count, exp_qb);
        mode_we = 1; mode_sel = 0; mode_wdata = 8'h5A; step(); mode_we = 0;
        chk("R8", "write after wake", mode0, 8'h5A);
    endtask

    task automatic t_wrap_sleep();
        int start;
        start = exp_qb;
        sleep_req = 1; step();
        chk("R4", "copy second entry", sleep_count, start);
        slp_inc = 8'd255;
        for (int i = 0; i < 100; i++) begin
            slp_en = 1; step();
            if (sleep_count > 4999) chk("R9", "range", sleep_count, 4999);
        end
        slp_en = 0;
        chk("R9", "modulo after 100x255", sleep_count, (start + 100 * 255) % 5000);
        start = (start + 100 * 255) % 5000;
        slp_inc = 8'd0;
        slp_en = 1; repeat (8) step(); slp_en = 0;
        chk("R5", "zero step holds", sleep_count, start);
        sleep_req = 0; step();
        exp_qb = start;
        chk("R6", "copy back second exit", qb_count, start);
    endtask

    initial begin
        t_reset();
        t_count();
        t_wrap();
        t_sleep_handover();
        t_wrap_sleep();
        report();
    end
endmodule